// File: doc/BRIEF.md
# SMBus Target with Read Stretching and Attention Status

This block is the target (slave) side of an SMBus/I2C link. It watches the SCL and SDA wires through a two-flop synchronizer on the system clock and pulls either wire low through its own output-enable signal, open-drain style. It acknowledges a programmable 7-bit address, but only once an address-valid flag and an enable bit are both set. On a write it acknowledges each data byte and latches it for the host. On a read it returns a byte that the host loaded beforehand.

The host sees four byte-wide registers. A matching read sets a sticky read-request status bit. While that bit is set, the target holds SCL low, so firmware has time to prepare the data before writing 1 to release the bus. The end of a matched transaction, marked by a STOP or a repeated START, sets a sticky cycle-complete bit. Firmware clears both bits by writing 1 to them. A separate input marks the current cycle as an address-resolution cycle. Such cycles still show as busy but never set the sticky bits. The attention output is the OR of the two sticky bits.

Top module: `smbt_attn_slave`

## Requirements
- R1: After reset, every register reads 0, neither wire is pulled low and attention is 0.
- R2: The target acknowledges an address byte (SDA low in the ninth clock) only when all three conditions hold: the valid flag (register 3, bit 0) is 1, the enable (register 0, bit 0) is 1, and the seven address bits on the wire equal register 0 bits 7:1. In every other case it leaves SDA released.
- R3: After a matched write address, each data byte is acknowledged and can be read from register 2.
- R4: A matched read address (R/W bit 1) sets status bit 2 (register 1) and raises attention.
- R5: While status bit 2 is set, the target holds SCL low once the read data phase is reached. It releases SCL after firmware clears the bit.
- R6: Read data is the byte last written to register 2, sent MSB first and repeated for each byte the master acknowledges. A NACK from the master ends the read. SDA from the target changes only while SCL is low.
- R7: Status bit 1 is set by a STOP or by a repeated START that follows an address-matched transaction.
- R8: Writing 1 to status bit 2 or bit 1 clears that bit, and writing 0 leaves it unchanged. If a hardware set and a host clear of the same bit fall in the same cycle, the set wins.
- R9: Status bit 0 (busy) is 1 from a START until the following STOP and is 0 when idle. Host writes to it have no effect.
- R10: While the ARP-cycle input is high, the target sets neither status bit 2 nor status bit 1. Busy still reads 1 during such a cycle.
- R11: Attention equals status bit 2 OR status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| arp_i | input | 1 | Marks the current cycle as an address-resolution cycle |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_sel_i | input | 2 | Register select: 0 address/enable, 1 status, 2 data, 3 valid flag |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Host read data for the selected register (register 2 reads the received byte) |
| attn_o | output | 1 | Attention request |

## Verification
The collision that matters is a host write-1-clear of cycle-complete that lands in the same clock as the STOP that sets the bit again. The bench first completes one matched write so that the bit is already set. It then runs a second matched write, raises SDA for the STOP, and counts the synchronizer and edge-detector stages so that the clearing write is presented in exactly the cycle the STOP is recognised. The bit must still read 1 afterwards. A later lone clear must then bring it to 0, which shows that the set won and that the clear itself still works.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int SEL_W  = 2;

    localparam logic [SEL_W-1:0] SEL_CTL   = 2'd0;
    localparam logic [SEL_W-1:0] SEL_STAT  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_DATA  = 2'd2;
    localparam logic [SEL_W-1:0] SEL_VALID = 2'd3;

    localparam int ST_BUSY  = 0;
    localparam int ST_DONE  = 1;
    localparam int ST_RDREQ = 2;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_AWAIT, S_AACK,
        S_WR, S_WWAIT, S_WACK,
        S_RD, S_RACK, S_RNEXT, S_IGN
    } smbt_state_e;

endpackage

// File: rtl/smbt_line_sync.sv
module smbt_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_sh   = {sync_q.scl_sh[STAGES-2:0], scl_in};
        sync_d.sda_sh   = {sync_q.sda_sh[STAGES-2:0], sda_in};
        sync_d.scl_prev = sync_q.scl_sh[STAGES-1];
        sync_d.sda_prev = sync_q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign scl_s     = sync_q.scl_sh[STAGES-1];
    assign sda_s     = sync_q.sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~sync_q.scl_prev;
    assign scl_fall  = ~scl_s & sync_q.scl_prev;
    assign start_evt = scl_s & sync_q.scl_prev & sync_q.sda_prev & ~sda_s;
    assign stop_evt  = scl_s & sync_q.scl_prev & ~sync_q.sda_prev & sda_s;

endmodule

// File: rtl/smbt_target_fsm.sv
module smbt_target_fsm
    import smbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              arp_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              slave_en_i,
    input  logic              addr_valid_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    input  logic              rdreq_i,
    output logic              set_rdreq_o,
    output logic              set_done_o,
    output logic              rx_load_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              busy_o,
    output logic              sda_oe_o,
    output logic              scl_oe_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

    typedef struct packed {
        smbt_state_e       st;
        logic [BYTE_W-1:0] shift;
        logic [CNT_W-1:0]  cnt;
        logic              sda_oe;
        logic              matched;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic hit;

    assign hit = (fsm_q.shift[BYTE_W-1:1] == own_addr_i) && slave_en_i && addr_valid_i;

    always_comb begin
        fsm_d       = fsm_q;
        set_rdreq_o = 1'b0;
        set_done_o  = 1'b0;
        rx_load_o   = 1'b0;
        if (start_evt || stop_evt) begin
            set_done_o    = fsm_q.matched && !arp_i;
            fsm_d.st      = start_evt ? S_ADDR : S_IDLE;
            fsm_d.cnt     = '0;
            fsm_d.matched = 1'b0;
            fsm_d.sda_oe  = 1'b0;
        end else begin
            unique case (fsm_q.st)
                S_ADDR, S_WR: if (scl_rise) begin
                    fsm_d.shift = {fsm_q.shift[BYTE_W-2:0], sda_s};
                    fsm_d.cnt   = fsm_q.cnt + 1'b1;
                    if (fsm_q.cnt == LAST_BIT)
                        fsm_d.st = (fsm_q.st == S_ADDR) ? S_AWAIT : S_WWAIT;
                end
                S_AWAIT: if (scl_fall) begin
                    if (hit) begin
                        fsm_d.matched = 1'b1;
                        fsm_d.sda_oe  = 1'b1;
                        fsm_d.st      = S_AACK;
                    end else begin
                        fsm_d.st = S_IGN;
                    end
                end
                S_AACK: if (scl_fall) begin
                    fsm_d.cnt = '0;
                    if (fsm_q.shift[0]) begin
                        fsm_d.shift  = tx_byte_i;
                        fsm_d.sda_oe = ~tx_byte_i[BYTE_W-1];
                        fsm_d.st     = S_RD;
                        set_rdreq_o  = !arp_i;
                    end else begin
                        fsm_d.sda_oe = 1'b0;
                        fsm_d.st     = S_WR;
                    end
                end
                S_WWAIT: if (scl_fall) begin
                    rx_load_o    = 1'b1;
                    fsm_d.sda_oe = 1'b1;
                    fsm_d.st     = S_WACK;
                end
                S_WACK: if (scl_fall) begin
                    fsm_d.sda_oe = 1'b0;
                    fsm_d.cnt    = '0;
                    fsm_d.st     = S_WR;
                end
                S_RD: begin
                    if (scl_rise) fsm_d.cnt = fsm_q.cnt + 1'b1;
                    if (scl_fall) begin
                        if (fsm_q.cnt == ALL_BITS) begin
                            fsm_d.sda_oe = 1'b0;
                            fsm_d.st     = S_RACK;
                        end else begin
                            fsm_d.shift  = {fsm_q.shift[BYTE_W-2:0], 1'b0};
                            fsm_d.sda_oe = ~fsm_q.shift[BYTE_W-2];
                        end
                    end
                end
                S_RACK: if (scl_rise) fsm_d.st = sda_s ? S_IGN : S_RNEXT;
                S_RNEXT: if (scl_fall) begin
                    fsm_d.shift  = tx_byte_i;
                    fsm_d.sda_oe = ~tx_byte_i[BYTE_W-1];
                    fsm_d.cnt    = '0;
                    fsm_d.st     = S_RD;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: S_IDLE, shift: '0, cnt: '0, sda_oe: 1'b0, matched: 1'b0};
        else        fsm_q <= fsm_d;
    end

    assign rx_byte_o = fsm_q.shift;
    assign busy_o    = (fsm_q.st != S_IDLE);
    assign sda_oe_o  = fsm_q.sda_oe;
    assign scl_oe_o  = rdreq_i && (fsm_q.st == S_RD);

    // R6
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fsm_q.sda_oe) |-> !scl_s);

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !busy_o);

endmodule

// File: rtl/smbt_regs.sv
module smbt_regs
    import smbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o,
    input  logic              set_rdreq_i,
    input  logic              set_done_i,
    input  logic              rx_load_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  logic              busy_i,
    output logic [ADDR_W-1:0] own_addr_o,
    output logic              slave_en_o,
    output logic              addr_valid_o,
    output logic [BYTE_W-1:0] tx_byte_o,
    output logic              rdreq_o,
    output logic              done_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] ctl;
        logic              valid;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] rx;
        logic              rdreq;
        logic              done;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  clr_rdreq, clr_done;

    assign clr_rdreq = wr_i && (sel_i == SEL_STAT) && wdata_i[ST_RDREQ];
    assign clr_done  = wr_i && (sel_i == SEL_STAT) && wdata_i[ST_DONE];

    always_comb begin
        regs_d = regs_q;
        if (wr_i && sel_i == SEL_CTL)   regs_d.ctl   = wdata_i;
        if (wr_i && sel_i == SEL_VALID) regs_d.valid = wdata_i[0];
        if (wr_i && sel_i == SEL_DATA)  regs_d.tx    = wdata_i;
        if (rx_load_i)                  regs_d.rx    = rx_byte_i;
        regs_d.rdreq = set_rdreq_i || (regs_q.rdreq && !clr_rdreq);
        regs_d.done  = set_done_i  || (regs_q.done  && !clr_done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        unique case (sel_i)
            SEL_CTL:  rdata_o = regs_q.ctl;
            SEL_STAT: rdata_o = {{(BYTE_W-3){1'b0}}, regs_q.rdreq, regs_q.done, busy_i};
            SEL_DATA: rdata_o = regs_q.rx;
            default:  rdata_o = {{(BYTE_W-1){1'b0}}, regs_q.valid};
        endcase
    end

    assign own_addr_o   = regs_q.ctl[BYTE_W-1:1];
    assign slave_en_o   = regs_q.ctl[0];
    assign addr_valid_o = regs_q.valid;
    assign tx_byte_o    = regs_q.tx;
    assign rdreq_o      = regs_q.rdreq;
    assign done_o       = regs_q.done;

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.done && !clr_done |=> regs_q.done);

    // R8
    rdreq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.rdreq && !clr_rdreq |=> regs_q.rdreq);

endmodule

// File: rtl/smbt_attn_slave.sv
module smbt_attn_slave
    import smbt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    input  logic              arp_i,
    input  logic              reg_wr_i,
    input  logic [SEL_W-1:0]  reg_sel_i,
    input  logic [BYTE_W-1:0] reg_wdata_i,
    output logic [BYTE_W-1:0] reg_rdata_o,
    output logic              attn_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic set_rdreq, set_done, rx_load, busy, slave_en, addr_valid, rdreq, done;
    logic [BYTE_W-1:0] rx_byte, tx_byte;
    logic [ADDR_W-1:0] own_addr;

    smbt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    smbt_target_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt), .arp_i(arp_i),
        .own_addr_i(own_addr), .slave_en_i(slave_en), .addr_valid_i(addr_valid),
        .tx_byte_i(tx_byte), .rdreq_i(rdreq),
        .set_rdreq_o(set_rdreq), .set_done_o(set_done),
        .rx_load_o(rx_load), .rx_byte_o(rx_byte), .busy_o(busy),
        .sda_oe_o(sda_oe_o), .scl_oe_o(scl_oe_o)
    );

    smbt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .sel_i(reg_sel_i),
        .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
        .set_rdreq_i(set_rdreq), .set_done_i(set_done),
        .rx_load_i(rx_load), .rx_byte_i(rx_byte), .busy_i(busy),
        .own_addr_o(own_addr), .slave_en_o(slave_en), .addr_valid_o(addr_valid),
        .tx_byte_o(tx_byte), .rdreq_o(rdreq), .done_o(done)
    );

    assign attn_o = rdreq | done;

    // R5
    stretch_needs_rdreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdreq |-> !scl_oe_o);

    // R10
    arp_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !$past(arp_i));

endmodule

// File: tb/sim_smbt_attn_slave.sv
module sim_smbt_attn_slave;
    localparam int CLK_NS = 10;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, arp = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic scl_oe, sda_oe, attn, scl_line, sda_line;
    int errors = 0, checks = 0;

    always #(CLK_NS/2) clk = ~clk;
    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;

    smbt_attn_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .arp_i(arp),
        .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .attn_o(attn)
    );

    typedef struct packed {
        logic [6:0] own;
        logic       en;
        logic       valid;
        logic [6:0] tgt;
        logic [7:0] data;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{7'h21, 1'b1, 1'b1, 7'h21, 8'h5C},
        '{7'h21, 1'b1, 1'b1, 7'h22, 8'h11},
        '{7'h21, 1'b0, 1'b1, 7'h21, 8'h33},
        '{7'h21, 1'b1, 1'b0, 7'h21, 8'h44},
        '{7'h7F, 1'b1, 1'b1, 7'h7F, 8'hFF},
        '{7'h00, 1'b1, 1'b1, 7'h00, 8'h81}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic host_wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic m_start();
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic m_stop();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b1; wait_q();
    endtask

    task automatic wr_bit(input logic b);
        m_sda = b; wait_q();
        m_scl = 1'b1; wait_scl_high(); wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic rd_bit(output logic b);
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_scl_high(); wait_q();
        b = sda_line;
        m_scl = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack_n);
        for (int i = 7; i >= 0; i--) wr_bit(v[i]);
        rd_bit(ack_n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d, rb0, rb1;
        logic ack_a, ack_d, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            host_rd(2'(s), d);
            check(d == 8'h00, "R1", d, 0);
        end
        check(!scl_oe && !sda_oe && !attn, "R1", {scl_oe, sda_oe, attn}, 0);

        // table walk: R2 address match, R3 write data, R7 stop completion
        for (int v = 0; v < 6; v++) begin
            logic exp_ack;
            exp_ack = VECS[v].en && VECS[v].valid && (VECS[v].own == VECS[v].tgt);
            host_wr(2'd0, {VECS[v].own, VECS[v].en});
            host_wr(2'd3, {7'd0, VECS[v].valid});
            m_start();
            send_byte({VECS[v].tgt, 1'b0}, ack_a);
            send_byte(VECS[v].data, ack_d);
            m_stop();
            repeat (4) @(negedge clk);
            check(ack_a == !exp_ack, "R2", ack_a, !exp_ack);
            check(ack_d == !exp_ack, "R3", ack_d, !exp_ack);
            host_rd(2'd1, d);
            check(d[1] == exp_ack, "R7", d[1], exp_ack);
            if (exp_ack) begin
                host_rd(2'd2, d);
                check(d == VECS[v].data, "R3", d, VECS[v].data);
            end
            host_wr(2'd1, 8'h06);
        end

        // R9 busy during transfer, R10 ARP cycle keeps sticky bits clear
        host_wr(2'd0, {7'h21, 1'b1});
        host_wr(2'd3, 8'h01);
        arp = 1'b1;
        m_start();
        send_byte({7'h21, 1'b0}, ack_a);
        host_rd(2'd1, d);
        check(d[0] == 1'b1, "R9", d[0], 1);
        send_byte(8'h77, ack_d);
        m_stop();
        repeat (4) @(negedge clk);
        host_rd(2'd1, d);
        check(d == 8'h00, "R10", d, 0);
        arp = 1'b0;

        // R9 busy is read-only
        host_wr(2'd1, 8'h01);
        host_rd(2'd1, d);
        check(d[0] == 1'b0, "R9", d[0], 0);

        // R7 repeated START after a matched write
        m_start();
        send_byte({7'h21, 1'b0}, ack_a);
        send_byte(8'h3C, ack_d);
        m_start();
        repeat (4) @(negedge clk);
        host_rd(2'd1, d);
        check(d[1] == 1'b1, "R7", d[1], 1);
        send_byte({7'h55, 1'b0}, ack_a);
        m_stop();
        check(ack_a == 1'b1, "R2", ack_a, 1);

        // R8 write 0 leaves status unchanged
        host_wr(2'd1, 8'h00);
        host_rd(2'd1, d);
        check(d[1] == 1'b1, "R8", d[1], 1);
        check(attn == 1'b1, "R11", attn, 1);

        // R8 set and clear in the same cycle: set wins
        m_start();
        send_byte({7'h21, 1'b0}, ack_a);
        send_byte(8'h99, ack_d);
        m_sda = 1'b0; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 8'h02;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (4) @(negedge clk);
        host_rd(2'd1, d);
        check(d[1] == 1'b1, "R8", d[1], 1);
        host_wr(2'd1, 8'h02);
        host_rd(2'd1, d);
        check(d[1] == 1'b0, "R8", d[1], 0);
        check(attn == 1'b0, "R11", attn, 0);

        // R4 read request, R5 stretching, R6 read data
        host_wr(2'd2, 8'hA5);
        m_start();
        send_byte({7'h21, 1'b1}, ack_a);
        check(ack_a == 1'b0, "R2", ack_a, 0);
        repeat (10) @(negedge clk);
        host_rd(2'd1, d);
        check(d[2] == 1'b1, "R4", d[2], 1);
        check(attn == 1'b1, "R11", attn, 1);
        m_scl = 1'b1;
        repeat (20) @(negedge clk);
        check(scl_line == 1'b0, "R5", scl_line, 0);
        host_wr(2'd1, 8'h04);
        repeat (6) @(negedge clk);
        check(scl_line == 1'b1, "R5", scl_line, 1);
        check(attn == 1'b0, "R11", attn, 0);
        wait_q();
        rb0[7] = sda_line;
        m_scl = 1'b0; wait_q();
        for (int i = 6; i >= 0; i--) begin
            rd_bit(b);
            rb0[i] = b;
        end
        wr_bit(1'b0);
        for (int i = 7; i >= 0; i--) begin
            rd_bit(b);
            rb1[i] = b;
        end
        wr_bit(1'b1);
        check(rb0 == 8'hA5, "R6", rb0, 8'hA5);
        check(rb1 == 8'hA5, "R6", rb1, 8'hA5);
        check(sda_oe == 1'b0, "R6", sda_oe, 0);
        m_stop();
        repeat (4) @(negedge clk);
        host_rd(2'd1, d);
        check(d == 8'h02, "R7", d, 8'h02);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule